// File: doc/BRIEF.md
# Halt Group Cross-Trigger

This block ties harts and external trigger lines together into halt groups so that a stop on one member brings the rest of its group to a stop. Every hart, every trigger input and every trigger output owns a small group-number register, written through a simple configuration port. Group 0 stands for "not grouped". Any other number forms a group.

A group event happens in a cycle where a hart of a nonzero group shows a rising edge on its halted signal, or a trigger input of a nonzero group is high. In the following cycle the block raises a halt request to every hart in that group and asserts every trigger output of that group for one cycle. A hart's group halt request stays up until the hart reports halted. The block only detects edges: it leaves the debugger's own halt path and the resume logic to the rest of the debug unit.

Top module: `hg_cross_halt`

## Requirements
- R1: After reset every group register reads 0, and all halt requests and trigger outputs are low.
- R2: A write with `cfg_we` high stores `cfg_wgrp` into the member chosen by `cfg_kind` (0 hart, 1 trigger input, 2 trigger output) and `cfg_idx`. A value of `N_GROUPS` or more is stored as 0. `cfg_rgrp` shows the stored value of the addressed member in the same cycle. An index beyond the member count is ignored and reads 0.
- R3: A rising edge of `hart_halted[i]` while hart i is in nonzero group g sets `hart_grp_haltreq` of every hart in group g, the halting hart included, in the next cycle.
- R4: A hart's group halt request stays high while that hart is not halted. It drops one cycle after the hart is seen halted, provided no new event of its group arrives.
- R5: A trigger input that is high while assigned to nonzero group g causes the same next-cycle halt requests and trigger-output pulses as a hart halting in g.
- R6: A trigger output in group g is high exactly in the cycles that follow a group-g event cycle. A single event therefore gives a one-cycle pulse with one cycle of latency.
- R7: Members of group 0 never cause or receive any halt request or trigger pulse.
- R8: Moving an already halted hart into a group causes no halt request and no trigger pulse.
- R9: After a group resume, if one member halts again while another member has already dropped halted, the other member receives a request that it keeps until it halts. A member still showing halted at that moment gets the one-cycle request as well.
- R10: An event in one group changes no request or trigger output that belongs to another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hart_halted | input | N_HARTS | Halted status of each hart |
| trig_in | input | N_TIN | External trigger inputs, active high |
| cfg_we | input | 1 | Group-number write strobe |
| cfg_kind | input | 2 | Member class: 0 hart, 1 trigger input, 2 trigger output |
| cfg_idx | input | IDX_W | Member index within the class |
| cfg_wgrp | input | 5 | Group number to write |
| cfg_rgrp | output | 5 | Stored group number of the addressed member |
| hart_grp_haltreq | output | N_HARTS | Group halt request to each hart |
| trig_out | output | N_TOUT | External trigger outputs, one-cycle pulses |

## Verification
The bench goes after the places where edge and level are easily mixed up. If a hart that is already halted joins a group and the design triggers on the halted level, the group halts at once. If the design drops a request the moment any hart halts, and not when the target hart itself halts, a resumed member escapes the re-halt after a group resume. The bench checks that trigger outputs last a single cycle and that group 0 stays inert. A design that let group 0 act as a shared group would halt unrelated harts. It also writes out-of-range group numbers and indexes, where a design without the clamp would read back a group that does not exist.

// File: rtl/hg_pkg.sv
`timescale 1ns/1ps
package hg_pkg;
  localparam int GRP_W = 5;
  typedef logic [GRP_W-1:0] grp_t;

  typedef enum logic [1:0] {
    MEM_HART = 2'd0,
    MEM_TIN  = 2'd1,
    MEM_TOUT = 2'd2
  } mem_kind_e;

  // Clamp a written group number to the implemented range; illegal -> group 0.
  function automatic grp_t legal_grp(grp_t v, int unsigned ngroups);
    return (32'(v) < ngroups) ? v : '0;
  endfunction

  // Member participates in group g (group 0 never participates).
  function automatic logic grp_match(grp_t member, int unsigned g);
    return (g != 0) && (32'(member) == g);
  endfunction
endpackage

// File: rtl/hg_member_cfg.sv
`timescale 1ns/1ps
module hg_member_cfg
  import hg_pkg::*;
#(
  parameter int        N_MEM    = 4,
  parameter int        IDX_W    = 2,
  parameter int        N_GROUPS = 4,
  parameter mem_kind_e KIND     = MEM_HART
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_kind,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [GRP_W-1:0]            cfg_wgrp,
  output logic [N_MEM-1:0][GRP_W-1:0] grp_o,
  output logic [GRP_W-1:0]            rd_o
);
  logic kind_hit;
  assign kind_hit = (cfg_kind == KIND);

  for (genvar i = 0; i < N_MEM; i++) begin : g_mem
    logic sel;
    assign sel = kind_hit && (cfg_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              grp_o[i] <= '0;
      else if (cfg_we && sel)  grp_o[i] <= legal_grp(cfg_wgrp, N_GROUPS);
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < N_MEM; i++)
      if (kind_hit && (cfg_idx == IDX_W'(i))) rd_o = grp_o[i];
  end
endmodule

// File: rtl/hg_event_detect.sv
`timescale 1ns/1ps
module hg_event_detect
  import hg_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int N_TIN    = 2,
  parameter int N_GROUPS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_HARTS-1:0]            hart_halted,
  input  logic [N_TIN-1:0]              trig_in,
  input  logic [N_HARTS-1:0][GRP_W-1:0] hart_grp,
  input  logic [N_TIN-1:0][GRP_W-1:0]   tin_grp,
  output logic [N_HARTS-1:0]            halt_rise,
  output logic [N_GROUPS-1:0]           group_fire
);
  logic [N_HARTS-1:0] halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= '0;
    else        halted_q <= hart_halted;
  end

  assign halt_rise = hart_halted & ~halted_q;

  always_comb begin
    group_fire = '0;
    for (int g = 1; g < N_GROUPS; g++) begin
      for (int i = 0; i < N_HARTS; i++)
        if (halt_rise[i] && grp_match(hart_grp[i], g)) group_fire[g] = 1'b1;
      for (int t = 0; t < N_TIN; t++)
        if (trig_in[t] && grp_match(tin_grp[t], g)) group_fire[g] = 1'b1;
    end
  end
endmodule

// File: rtl/hg_request.sv
`timescale 1ns/1ps
module hg_request
  import hg_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int N_TOUT   = 2,
  parameter int N_GROUPS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_HARTS-1:0]            hart_halted,
  input  logic [N_GROUPS-1:0]           group_fire,
  input  logic [N_HARTS-1:0][GRP_W-1:0] hart_grp,
  input  logic [N_TOUT-1:0][GRP_W-1:0]  tout_grp,
  output logic [N_HARTS-1:0]            hart_fire,
  output logic [N_TOUT-1:0]             tout_fire,
  output logic [N_HARTS-1:0]            hart_req,
  output logic [N_TOUT-1:0]             trig_out
);
  always_comb begin
    hart_fire = '0;
    tout_fire = '0;
    for (int g = 1; g < N_GROUPS; g++) begin
      for (int i = 0; i < N_HARTS; i++)
        if (group_fire[g] && grp_match(hart_grp[i], g)) hart_fire[i] = 1'b1;
      for (int k = 0; k < N_TOUT; k++)
        if (group_fire[g] && grp_match(tout_grp[k], g)) tout_fire[k] = 1'b1;
    end
  end

  // A new event sets the request; it is held until the hart reports halted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hart_req <= '0;
      trig_out <= '0;
    end else begin
      hart_req <= hart_fire | (hart_req & ~hart_halted);
      trig_out <= tout_fire;
    end
  end
endmodule

// File: rtl/hg_cross_halt.sv
`timescale 1ns/1ps
module hg_cross_halt
  import hg_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int N_TIN    = 2,
  parameter int N_TOUT   = 2,
  parameter int N_GROUPS = 4,
  localparam int MAX_A   = (N_HARTS > N_TIN) ? N_HARTS : N_TIN,
  localparam int MAX_MEM = (MAX_A > N_TOUT) ? MAX_A : N_TOUT,
  localparam int IDX_W   = (MAX_MEM > 1) ? $clog2(MAX_MEM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_HARTS-1:0] hart_halted,
  input  logic [N_TIN-1:0]   trig_in,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_kind,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [4:0]         cfg_wgrp,
  output logic [4:0]         cfg_rgrp,
  output logic [N_HARTS-1:0] hart_grp_haltreq,
  output logic [N_TOUT-1:0]  trig_out
);
  logic [N_HARTS-1:0][GRP_W-1:0] hart_grp;
  logic [N_TIN-1:0][GRP_W-1:0]   tin_grp;
  logic [N_TOUT-1:0][GRP_W-1:0]  tout_grp;
  logic [GRP_W-1:0]              rd_hart, rd_tin, rd_tout;
  logic [N_HARTS-1:0]            halt_rise;
  logic [N_GROUPS-1:0]           group_fire;
  logic [N_HARTS-1:0]            hart_fire;
  logic [N_TOUT-1:0]             tout_fire;

  hg_member_cfg #(.N_MEM(N_HARTS), .IDX_W(IDX_W), .N_GROUPS(N_GROUPS), .KIND(MEM_HART)) u_cfg_hart (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wgrp(cfg_wgrp), .grp_o(hart_grp), .rd_o(rd_hart));

  hg_member_cfg #(.N_MEM(N_TIN), .IDX_W(IDX_W), .N_GROUPS(N_GROUPS), .KIND(MEM_TIN)) u_cfg_tin (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wgrp(cfg_wgrp), .grp_o(tin_grp), .rd_o(rd_tin));

  hg_member_cfg #(.N_MEM(N_TOUT), .IDX_W(IDX_W), .N_GROUPS(N_GROUPS), .KIND(MEM_TOUT)) u_cfg_tout (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wgrp(cfg_wgrp), .grp_o(tout_grp), .rd_o(rd_tout));

  assign cfg_rgrp = rd_hart | rd_tin | rd_tout;

  hg_event_detect #(.N_HARTS(N_HARTS), .N_TIN(N_TIN), .N_GROUPS(N_GROUPS)) u_detect (
    .clk(clk), .rst_n(rst_n), .hart_halted(hart_halted), .trig_in(trig_in),
    .hart_grp(hart_grp), .tin_grp(tin_grp), .halt_rise(halt_rise), .group_fire(group_fire));

  hg_request #(.N_HARTS(N_HARTS), .N_TOUT(N_TOUT), .N_GROUPS(N_GROUPS)) u_req (
    .clk(clk), .rst_n(rst_n), .hart_halted(hart_halted), .group_fire(group_fire),
    .hart_grp(hart_grp), .tout_grp(tout_grp), .hart_fire(hart_fire), .tout_fire(tout_fire),
    .hart_req(hart_grp_haltreq), .trig_out(trig_out));
endmodule

// File: rtl/hg_cross_halt_sva.sv
`timescale 1ns/1ps
module hg_cross_halt_sva
  import hg_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int N_TOUT   = 2,
  parameter int N_GROUPS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_HARTS-1:0]            hart_halted,
  input logic [N_HARTS-1:0]            hart_grp_haltreq,
  input logic [N_TOUT-1:0]             trig_out,
  input logic [GRP_W-1:0]              cfg_rgrp,
  input logic [N_HARTS-1:0]            hart_fire,
  input logic [N_TOUT-1:0]             tout_fire,
  input logic [N_TOUT-1:0][GRP_W-1:0]  tout_grp
);
  p_readback_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cfg_rgrp) < N_GROUPS);

  for (genvar i = 0; i < N_HARTS; i++) begin : g_hart
    p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hart_grp_haltreq[i]) |-> $past(hart_fire[i]));
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_grp_haltreq[i] && !hart_halted[i]) |=> hart_grp_haltreq[i]);
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_grp_haltreq[i] && hart_halted[i] && !hart_fire[i]) |=> !hart_grp_haltreq[i]);
  end

  for (genvar k = 0; k < N_TOUT; k++) begin : g_tout
    p_tout_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tout_fire[k] |=> trig_out[k]);
    p_tout_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[k] |-> $past(tout_fire[k]));
    p_tout_group0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[k] |-> ($past(tout_grp[k]) != '0));
  end
endmodule

bind hg_cross_halt hg_cross_halt_sva #(
  .N_HARTS(N_HARTS), .N_TOUT(N_TOUT), .N_GROUPS(N_GROUPS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .hart_halted(hart_halted),
  .hart_grp_haltreq(hart_grp_haltreq), .trig_out(trig_out), .cfg_rgrp(cfg_rgrp),
  .hart_fire(hart_fire), .tout_fire(tout_fire), .tout_grp(tout_grp)
);

// File: tb/hg_cross_halt_test.sv
`timescale 1ns/1ps
module hg_cross_halt_test;
  localparam int NH = 4, NTI = 2, NTO = 2, NG = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NH-1:0]  hart_halted = '0;
  logic [NTI-1:0] trig_in = '0;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_kind = '0;
  logic [1:0]     cfg_idx = '0;
  logic [4:0]     cfg_wgrp = '0;
  logic [4:0]     cfg_rgrp;
  logic [NH-1:0]  hart_grp_haltreq;
  logic [NTO-1:0] trig_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hg_cross_halt #(.N_HARTS(NH), .N_TIN(NTI), .N_TOUT(NTO), .N_GROUPS(NG)) uut (
    .clk(clk), .rst_n(rst_n), .hart_halted(hart_halted), .trig_in(trig_in),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wgrp(cfg_wgrp),
    .cfg_rgrp(cfg_rgrp), .hart_grp_haltreq(hart_grp_haltreq), .trig_out(trig_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hart_halted = '0; trig_in = '0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] kind, logic [1:0] idx, logic [4:0] grp);
    cfg_kind = kind; cfg_idx = idx; cfg_wgrp = grp; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] kind, logic [1:0] idx, logic [4:0] exp);
    cfg_kind = kind; cfg_idx = idx;
    #1 check(req, 32'(cfg_rgrp), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 haltreq", 32'(hart_grp_haltreq), 0);
    check("R1 trig_out", 32'(trig_out), 0);
    rd_check("R1 hart2 grp", 2'd0, 2'd2, 5'd0);
    rd_check("R1 tout1 grp", 2'd2, 2'd1, 5'd0);
  endtask

  task automatic t_config();
    do_reset();
    wr(2'd0, 2'd0, 5'd1);  rd_check("R2 legal write", 2'd0, 2'd0, 5'd1);
    wr(2'd0, 2'd1, 5'd3);  rd_check("R2 top group", 2'd0, 2'd1, 5'd3);
    wr(2'd0, 2'd1, 5'd7);  rd_check("R2 clamp 7", 2'd0, 2'd1, 5'd0);
    wr(2'd2, 2'd0, 5'd31); rd_check("R2 clamp 31", 2'd2, 2'd0, 5'd0);
    wr(2'd1, 2'd3, 5'd2);  rd_check("R2 bad index", 2'd1, 2'd3, 5'd0);
    rd_check("R2 other kind untouched", 2'd1, 2'd1, 5'd0);
  endtask

  // harts 0,1 -> g1, hart 2 -> g2, hart 3 -> g0; tin0/tout0 -> g1, tin1/tout1 -> g2
  task automatic std_groups();
    wr(2'd0, 2'd0, 5'd1); wr(2'd0, 2'd1, 5'd1); wr(2'd0, 2'd2, 5'd2);
    wr(2'd1, 2'd0, 5'd1); wr(2'd1, 2'd1, 5'd2);
    wr(2'd2, 2'd0, 5'd1); wr(2'd2, 2'd1, 5'd2);
  endtask

  task automatic t_cross_halt();
    do_reset(); std_groups();
    hart_halted = 4'b0001;
    @(negedge clk);
    check("R3 group reqs", 32'(hart_grp_haltreq), 32'b0011);
    check("R6 pulse", 32'(trig_out), 32'b01);
    check("R10 other groups", 32'(hart_grp_haltreq[3:2]), 0);
    @(negedge clk);
    check("R6 pulse ends", 32'(trig_out), 0);
    check("R4 drop halted, hold running", 32'(hart_grp_haltreq), 32'b0010);
    repeat (3) @(negedge clk);
    check("R4 held", 32'(hart_grp_haltreq), 32'b0010);
    hart_halted = 4'b0011;
    @(negedge clk);
    check("R3 second halt retriggers", 32'(hart_grp_haltreq), 32'b0011);
    @(negedge clk);
    check("R4 all halted drop", 32'(hart_grp_haltreq), 0);
  endtask

  task automatic t_trig_in();
    do_reset(); std_groups();
    trig_in = 2'b10;
    @(negedge clk);
    trig_in = 2'b00;
    check("R5 trig in reqs", 32'(hart_grp_haltreq), 32'b0100);
    check("R5 trig out", 32'(trig_out), 32'b10);
    @(negedge clk);
    check("R6 single pulse", 32'(trig_out), 0);
    check("R4 held", 32'(hart_grp_haltreq), 32'b0100);
    trig_in = 2'b01;
    @(negedge clk);
    check("R6 held input repeats", 32'(trig_out), 32'b01);
    @(negedge clk);
    trig_in = 2'b00;
    check("R6 still high", 32'(trig_out), 32'b01);
    check("R5 both groups", 32'(hart_grp_haltreq), 32'b0111);
    @(negedge clk);
    check("R6 drops", 32'(trig_out), 0);
  endtask

  task automatic t_group0_join();
    do_reset();
    wr(2'd0, 2'd0, 5'd1); wr(2'd2, 2'd0, 5'd1);
    hart_halted = 4'b0010;
    @(negedge clk);
    check("R7 group0 no req", 32'(hart_grp_haltreq), 0);
    check("R7 group0 no pulse", 32'(trig_out), 0);
    wr(2'd0, 2'd1, 5'd1);
    repeat (2) @(negedge clk);
    check("R8 join no req", 32'(hart_grp_haltreq), 0);
    check("R8 join no pulse", 32'(trig_out), 0);
    hart_halted = 4'b0011;
    @(negedge clk);
    check("R8 member after join", 32'(hart_grp_haltreq), 32'b0011);
  endtask

  task automatic t_rehalt();
    do_reset();
    wr(2'd0, 2'd0, 5'd1); wr(2'd0, 2'd1, 5'd1); wr(2'd0, 2'd2, 5'd1);
    hart_halted = 4'b0111;
    repeat (3) @(negedge clk);
    check("R9 settled", 32'(hart_grp_haltreq), 0);
    hart_halted = 4'b0100;
    @(negedge clk);
    check("R9 resume no req", 32'(hart_grp_haltreq), 0);
    hart_halted = 4'b0101;
    @(negedge clk);
    check("R9 rehalt all", 32'(hart_grp_haltreq), 32'b0111);
    @(negedge clk);
    check("R9 resumed member held", 32'(hart_grp_haltreq), 32'b0010);
  endtask

  initial begin
    t_reset();
    t_config();
    t_cross_halt();
    t_trig_in();
    t_group0_join();
    t_rehalt();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule